// File: doc/BRIEF.md
# Conversion Result Averaging and Threshold Filter

This block sits between an analog-to-digital converter core and its result storage. Each raw 12-bit sample arrives as a valid/data pair. The block can sum a run of 4, 8, 16 or 32 consecutive samples and reduce that run to its mean. It then adds or subtracts a fixed user offset, with clamping at both ends of the 12-bit range. Finally it tests the adjusted value against a two-threshold condition.

The test decides whether the stored result is replaced and whether the conversion-complete flag is set. When the stored result is updated, the block can also pulse a DMA request and raise an interrupt line. A consumer clears the flag after it has taken the result. While overwrite protection is active, that clear is what lets the next result in. Configuration inputs are expected to stay fixed while a run of averaged samples is being collected.

Top module: `rpp_result_proc`

## Requirements
- R1: `avg_sel` codes 0, 1, 2 and 3 group 4, 8, 16 and 32 consecutive valid samples, and the group value is the sum of the group shifted right by 2, 3, 4 or 5 bits. Codes 4 to 7 pass each valid sample through on its own.
- R2: The offset is applied to the group value. With `ofs_sub`=0 it is added, clamping at 4095. With `ofs_sub`=1 it is subtracted, clamping at 0.
- R3: With `cmp_mode`=0 the condition holds when the adjusted value is below `thr_a`. With `cmp_mode`=1 it holds when the value is at least `thr_a`.
- R4: With `cmp_mode`=2, if `thr_a` ≤ `thr_b` the condition holds when the value is below `thr_a` or above `thr_b`. Otherwise it holds when the value is below `thr_a` and above `thr_b`.
- R5: With `cmp_mode`=3, if `thr_a` ≤ `thr_b` the condition holds when the value is at least `thr_a` and at most `thr_b`. Otherwise it holds when the value is at least `thr_a` or at most `thr_b`.
- R6: With `cmp_en`=0 every finished value is accepted. With `cmp_en`=1 only values meeting the condition are accepted. An accepted value appears on `result` and sets `done_flag` after the same clock edge that samples the finishing input. A rejected value leaves both unchanged.
- R7: While averaging is selected, `done_flag` can only set on the edge that samples the last sample of a group.
- R8: With `ovw_en`=0, a finished value is discarded while `done_flag` is already set. With `ovw_en`=1 it replaces the stored result.
- R9: `flag_clr` clears `done_flag` (and `irq_req`) at the next edge, unless a value is accepted on that edge, in which case the flag stays set.
- R10: `dma_req` is high for exactly one cycle after each accepted value when `dma_en`=1. `irq_req` equals `done_flag` gated by the `irq_en` sampled on the same edge.
- R11: After reset, `result` is 0, `done_flag`, `dma_req` and `irq_req` are 0, and the averaging group is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_valid | input | 1 | Raw sample present this cycle |
| raw_data | input | 12 | Raw sample value |
| avg_sel | input | 3 | Averaging code |
| ofs_val | input | 12 | Offset magnitude |
| ofs_sub | input | 1 | 1 = subtract offset, 0 = add |
| cmp_en | input | 1 | Enable threshold condition |
| cmp_mode | input | 2 | Condition selector |
| thr_a | input | 12 | First threshold |
| thr_b | input | 12 | Second threshold |
| ovw_en | input | 1 | Allow replacing an unread result |
| dma_en | input | 1 | Enable DMA request pulse |
| irq_en | input | 1 | Enable interrupt line |
| flag_clr | input | 1 | Clear the complete flag |
| result | output | 12 | Stored result |
| done_flag | output | 1 | Conversion-complete flag |
| dma_req | output | 1 | One-cycle DMA request |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a rejected or protected value never disturbs the stored result or raises the flag;
- the flag rises only on an edge where a group finishes;
- a clear without an accept drops the flag;
- the request lines never stand without the flag.

Only the bench scenarios can show the arithmetic: the group mean, the clamped offset, and the threshold decisions in each mode and ordering, including the equal-threshold boundaries. They also show that the group length matches each averaging code.

// File: rtl/rpp_pkg.sv
package rpp_pkg;
  localparam int DW = 12;

  typedef enum logic [1:0] {
    CMP_BELOW    = 2'd0,
    CMP_AT_LEAST = 2'd1,
    CMP_OUTSIDE  = 2'd2,
    CMP_INSIDE   = 2'd3
  } cmp_mode_e;

  // number of right-shift bits for an averaging code; 0 means bypass
  function automatic logic [2:0] avg_shift(input logic [2:0] code);
    return (code < 3'd4) ? (code + 3'd2) : 3'd0;
  endfunction

  // offset application with clamping to the unsigned range
  function automatic logic [DW-1:0] offset_apply(input logic [DW-1:0] v,
                                                 input logic [DW-1:0] o,
                                                 input logic sub);
    logic [DW:0] s;
    if (sub) begin
      s = {1'b0, v} - {1'b0, o};
      return s[DW] ? '0 : s[DW-1:0];
    end else begin
      s = {1'b0, v} + {1'b0, o};
      return s[DW] ? '1 : s[DW-1:0];
    end
  endfunction

  function automatic logic cmp_eval(input cmp_mode_e m, input logic [DW-1:0] v,
                                    input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic lo, hi, ordered;
    lo      = v < a;
    hi      = v > b;
    ordered = a <= b;
    case (m)
      CMP_BELOW:    return lo;
      CMP_AT_LEAST: return !lo;
      CMP_OUTSIDE:  return ordered ? (lo || hi) : (lo && hi);
      default:      return ordered ? (!lo && !hi) : (!lo || !hi);
    endcase
  endfunction
endpackage

// File: rtl/rpp_averager.sv
module rpp_averager
  import rpp_pkg::*;
#(
  parameter int DATA_W   = DW,
  parameter int MAX_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        avg_code,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int ACC_W = DATA_W + MAX_LOG2;
  localparam int CNT_W = MAX_LOG2 + 1;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       shift;
  logic             bypass;
  logic             last;
  logic [ACC_W-1:0] sum_nx;
  logic [ACC_W-1:0] mean;
  logic [CNT_W-1:0] limit;

  always_comb begin
    shift  = avg_shift(avg_code);
    bypass = (shift == 3'd0);
    limit  = CNT_W'((1 << shift) - 1);
    last   = (cnt_q == limit);
    sum_nx = acc_q + ACC_W'(in_data);
    mean   = sum_nx >> shift;
  end

  assign out_valid = in_valid && (bypass || last);
  assign out_data  = bypass ? in_data : mean[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (in_valid) begin
      if (bypass || last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= sum_nx;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rpp_adjust.sv
module rpp_adjust
  import rpp_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic [DATA_W-1:0] val_in,
  input  logic [DATA_W-1:0] ofs_val,
  input  logic              ofs_sub,
  input  logic              cmp_en,
  input  logic [1:0]        cmp_mode,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  output logic [DATA_W-1:0] val_out,
  output logic              pass
);
  always_comb begin
    val_out = offset_apply(val_in, ofs_val, ofs_sub);
    pass    = !cmp_en || cmp_eval(cmp_mode_e'(cmp_mode), val_out, thr_a, thr_b);
  end
endmodule

// File: rtl/rpp_store.sv
module rpp_store #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_valid,
  input  logic              pass,
  input  logic [DATA_W-1:0] val,
  input  logic              ovw_en,
  input  logic              dma_en,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              accept,
  output logic [DATA_W-1:0] result,
  output logic              done_flag,
  output logic              dma_req,
  output logic              irq_req
);
  logic flag_nx;

  always_comb begin
    accept  = fin_valid && pass && (!done_flag || ovw_en);
    flag_nx = accept ? 1'b1 : (flag_clr ? 1'b0 : done_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      done_flag <= 1'b0;
      dma_req   <= 1'b0;
      irq_req   <= 1'b0;
    end else begin
      if (accept) result <= val;
      done_flag <= flag_nx;
      dma_req   <= accept && dma_en;
      irq_req   <= flag_nx && irq_en;
    end
  end
endmodule

// File: rtl/rpp_result_proc.sv
module rpp_result_proc #(
  parameter int DATA_W   = 12,
  parameter int MAX_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [2:0]        avg_sel,
  input  logic [DATA_W-1:0] ofs_val,
  input  logic              ofs_sub,
  input  logic              cmp_en,
  input  logic [1:0]        cmp_mode,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  input  logic              ovw_en,
  input  logic              dma_en,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] result,
  output logic              done_flag,
  output logic              dma_req,
  output logic              irq_req
);
  logic              fin_valid;
  logic [DATA_W-1:0] fin_data;
  logic [DATA_W-1:0] adj_data;
  logic              cmp_pass;
  logic              accept;

  rpp_averager #(.DATA_W(DATA_W), .MAX_LOG2(MAX_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .in_valid(raw_valid), .in_data(raw_data),
    .avg_code(avg_sel), .out_valid(fin_valid), .out_data(fin_data)
  );

  rpp_adjust #(.DATA_W(DATA_W)) u_adj (
    .val_in(fin_data), .ofs_val(ofs_val), .ofs_sub(ofs_sub), .cmp_en(cmp_en),
    .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b),
    .val_out(adj_data), .pass(cmp_pass)
  );

  rpp_store #(.DATA_W(DATA_W)) u_st (
    .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .pass(cmp_pass),
    .val(adj_data), .ovw_en(ovw_en), .dma_en(dma_en), .irq_en(irq_en),
    .flag_clr(flag_clr), .accept(accept), .result(result),
    .done_flag(done_flag), .dma_req(dma_req), .irq_req(irq_req)
  );
endmodule

// File: rtl/rpp_result_proc_chk.sv
module rpp_result_proc_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              raw_valid,
  input logic              fin_valid,
  input logic              cmp_pass,
  input logic              accept,
  input logic              ovw_en,
  input logic              irq_en,
  input logic              flag_clr,
  input logic [DATA_W-1:0] result,
  input logic              done_flag,
  input logic              dma_req,
  input logic              irq_req
);
  p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && !cmp_pass) |=> ($stable(result) && !$rose(done_flag)));

  p_fin_on_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |-> raw_valid);

  p_set_needs_fin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(fin_valid));

  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !ovw_en) |=> $stable(result));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !accept) |=> !done_flag);

  p_dma_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> done_flag);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (done_flag && $past(irq_en)));
endmodule

bind rpp_result_proc rpp_result_proc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .fin_valid(fin_valid),
  .cmp_pass(cmp_pass), .accept(accept), .ovw_en(ovw_en), .irq_en(irq_en),
  .flag_clr(flag_clr), .result(result), .done_flag(done_flag),
  .dma_req(dma_req), .irq_req(irq_req)
);

// File: tb/tb_rpp_result_proc.sv
module tb_rpp_result_proc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_valid = 1'b0;
  logic [11:0] raw_data = '0;
  logic [2:0] avg_sel = 3'd4;
  logic [11:0] ofs_val = '0;
  logic ofs_sub = 1'b0;
  logic cmp_en = 1'b0;
  logic [1:0] cmp_mode = '0;
  logic [11:0] thr_a = '0, thr_b = '0;
  logic ovw_en = 1'b1, dma_en = 1'b1, irq_en = 1'b1, flag_clr = 1'b0;
  logic [11:0] result;
  logic done_flag, dma_req, irq_req;

  int n_chk = 0, n_bad = 0;
  int m_cnt = 0, m_sum = 0, m_res = 0;
  bit m_flag = 0, m_dma = 0, m_irq = 0, finished = 0;

  always #2.5 clk = ~clk;

  rpp_result_proc dut (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .avg_sel(avg_sel), .ofs_val(ofs_val), .ofs_sub(ofs_sub), .cmp_en(cmp_en),
    .cmp_mode(cmp_mode), .thr_a(thr_a), .thr_b(thr_b), .ovw_en(ovw_en),
    .dma_en(dma_en), .irq_en(irq_en), .flag_clr(flag_clr), .result(result),
    .done_flag(done_flag), .dma_req(dma_req), .irq_req(irq_req)
  );

  function automatic int group_len(input logic [2:0] c);
    case (c)
      3'd0: return 4;
      3'd1: return 8;
      3'd2: return 16;
      3'd3: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic int adjust(input int v);
    int r = ofs_sub ? v - int'(ofs_val) : v + int'(ofs_val);
    if (r < 0) r = 0;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  function automatic bit condition(input int v);
    int a = int'(thr_a), b = int'(thr_b);
    case (cmp_mode)
      2'd0: return v < a;
      2'd1: return v >= a;
      2'd2: return (a <= b) ? (v < a || v > b) : (v < a && v > b);
      default: return (a <= b) ? (v >= a && v <= b) : (v >= a || v <= b);
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input int d, input bit clr, input string tag);
    bit fin, acc;
    int val;
    raw_valid = v; raw_data = 12'(d); flag_clr = clr;
    fin = 0; val = 0;
    if (v) begin
      m_cnt++; m_sum += d;
      if (m_cnt == group_len(avg_sel)) begin
        fin = 1; val = m_sum / m_cnt; m_cnt = 0; m_sum = 0;
      end
    end
    val = adjust(val);
    acc = fin && (!cmp_en || condition(val)) && (!m_flag || ovw_en);
    if (acc) m_res = val;
    m_flag = acc ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_dma = acc && dma_en;
    m_irq = m_flag && irq_en;
    @(posedge clk); #1;
    raw_valid = 0; flag_clr = 0;
    chk(int'(result), m_res, {tag, " R6 result"});
    chk(int'(done_flag), int'(m_flag), {tag, " R6 flag"});
    chk(int'(dma_req), int'(m_dma), {tag, " R10 dma"});
    chk(int'(irq_req), int'(m_irq), {tag, " R10 irq"});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R11 reset state
    chk(int'(result), 0, "R11 result");
    chk(int'(done_flag), 0, "R11 flag");
    chk(int'(dma_req), 0, "R11 dma");
    chk(int'(irq_req), 0, "R11 irq");

    // R1 and R7: group of four, flag stays low until the fourth sample
    avg_sel = 3'd0;
    step(1, 100, 0, "R7 s1"); step(1, 200, 0, "R7 s2"); step(0, 0, 0, "R7 gap");
    step(1, 301, 0, "R7 s3");
    chk(int'(done_flag), 0, "R7 early flag");
    step(1, 402, 0, "R1 s4");
    chk(int'(result), 250, "R1 mean of four");
    step(0, 0, 1, "R9 clear");
    // R1 group of eight
    avg_sel = 3'd1;
    for (int i = 0; i < 8; i++) step(1, 4095, 0, "R1 eight");
    chk(int'(result), 4095, "R1 mean of eight");
    avg_sel = 3'd6;

    // R2 saturation both ways
    ofs_val = 12'd100; ofs_sub = 1;
    step(1, 50, 0, "R2 low");
    chk(int'(result), 0, "R2 clamp low");
    ofs_sub = 0;
    step(1, 4050, 0, "R2 high");
    chk(int'(result), 4095, "R2 clamp high");
    ofs_val = 0;

    // R3 boundaries
    cmp_en = 1; cmp_mode = 0; thr_a = 12'd500;
    step(1, 500, 1, "R3 mode0 equal rejected");
    step(1, 499, 0, "R3 mode0 below");
    cmp_mode = 1;
    step(1, 499, 0, "R3 mode1 below rejected");
    step(1, 500, 0, "R3 mode1 equal");
    // R4 both orderings
    cmp_mode = 2; thr_a = 12'd100; thr_b = 12'd200;
    step(1, 150, 0, "R4 inside rejected");
    step(1, 201, 0, "R4 above");
    thr_a = 12'd200; thr_b = 12'd100;
    step(1, 150, 0, "R4 swapped between");
    step(1, 250, 0, "R4 swapped rejected");
    // R5 both orderings
    cmp_mode = 3; thr_a = 12'd100; thr_b = 12'd200;
    step(1, 200, 0, "R5 upper edge");
    step(1, 201, 0, "R5 outside rejected");
    thr_a = 12'd200; thr_b = 12'd100;
    step(1, 150, 0, "R5 swapped rejected");
    step(1, 100, 0, "R5 swapped low edge");
    cmp_en = 0;

    // R8 overwrite protection, then R9 clear racing an accept
    ovw_en = 0;
    step(1, 777, 0, "R8 discard");
    chk(int'(result), 100, "R8 kept");
    step(1, 888, 1, "R9 clear and discard");
    step(1, 999, 1, "R9 accept beats clear");
    chk(int'(done_flag), 1, "R9 flag held");
    ovw_en = 1;

    // random mix
    for (int blk = 0; blk < 60; blk++) begin
      avg_sel = 3'($urandom % 7);
      ofs_val = 12'($urandom % 300); ofs_sub = 1'($urandom);
      cmp_en = 1'($urandom); cmp_mode = 2'($urandom);
      thr_a = 12'($urandom); thr_b = 12'($urandom);
      ovw_en = 1'($urandom); dma_en = 1'($urandom); irq_en = 1'($urandom);
      for (int i = 0; i < 64 || m_cnt != 0; i++)
        step(($urandom % 10) < 7, int'($urandom % 4096), ($urandom % 5) == 0, "rand R1 R2 R3 R4 R5 R8");
    end
    summary();
  end
endmodule